// File: doc/BRIEF.md
# Eight-Channel Edge/Level Interrupt Bank

The block watches eight external input lines and turns chosen events on them into pending interrupt bits. Each line is first resampled by a slow sampling clock (for example 32 kHz) through two flops, and the sampled level is then carried into the bus clock domain through a second two-flop synchronizer. Event detection runs in the bus domain by comparing the synchronized level with its value one bus cycle earlier.

Per channel, software picks edge or level detection, the active polarity, and whether both transitions count in edge mode. A detected event sets a sticky pending bit that software removes by writing a one to the clear location. Pending bits are gated by per-channel enables, and the gated bits are ORed onto one interrupt line. The synchronized input levels can be read back at any time.

Access is through a simple single-cycle register port: writes take effect at the bus clock edge, and read data is combinational from the address while a read is selected.

Top module: `irq_bank`

## Requirements
- R1: After reset all readable locations return zero and `irq` is low.
- R2: Offset 0x1C returns the synchronized level of channel i in bit i; writing it has no effect.
- R3: With mode bit i = 0 (offset 0x10) and both-edge bit i = 0 (offset 0x14), polarity bit i (offset 0x18) = 1 sets pending bit i (offset 0x04) on a low-to-high transition, and = 0 sets it on a high-to-low transition; nothing else sets it.
- R4: With mode bit i = 0 and both-edge bit i = 1, any transition of channel i sets pending bit i whatever the polarity bit.
- R5: With mode bit i = 1, pending bit i is set on every cycle in which the level equals the polarity bit (1 = high, 0 = low); a set on the same cycle as a clear wins, so the bit stays set while the level stays active.
- R6: Writing 1 to bit i of offset 0x0C clears pending bit i, zero bits leave their channels alone, and the location reads as zero.
- R7: Offset 0x08 returns pending AND enable (enable at offset 0x00); `irq` is the OR of those bits.
- R8: Enable, mode, both-edge and polarity locations read back the low eight bits last written, with bits 31:8 reading zero.
- R9: Writes to the pending (0x04) and gated (0x08) locations have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| smp_clk | input | 1 | Sampling clock for the input lines |
| smp_rst | input | 1 | Synchronous active-high reset, sampling domain |
| pins_in | input | 8 | External input lines, one per channel |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is selected |
| irq | output | 1 | Combined interrupt request |

## Verification
The two functions that can land on one bus cycle are a software clear of a pending bit and a fresh detection on the same channel; the design lets the detection win. The bench provokes this with level-mode channels whose input is still at its active level when the clear is written, and judges it by reading the pending location afterwards and expecting those bits still set while edge-mode bits have dropped. A checker assertion also watches every cycle for a pending bit that is low right after a detection.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_ENABLE = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_GATED  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_MODE   = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_BOTH   = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_POL    = 5'h18;
    localparam logic [ADDR_W-1:0] OFS_LEVEL  = 5'h1C;

    typedef enum logic {
        DET_EDGE  = 1'b0,
        DET_LEVEL = 1'b1
    } det_kind_e;

    typedef struct packed {
        det_kind_e kind;
        logic      both;
        logic      pol;
    } chan_cfg_t;

    // Event test for one channel from its present and previous sample.
    function automatic logic chan_hit(chan_cfg_t cfg, logic cur, logic prv);
        logic rise;
        logic fall;
        rise = cur & ~prv;
        fall = ~cur & prv;
        if (cfg.kind == DET_LEVEL)
            return cfg.pol ? cur : ~cur;
        if (cfg.both)
            return rise | fall;
        return cfg.pol ? rise : fall;
    endfunction

endpackage

// File: rtl/irq_bank_sync.sv
module irq_bank_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_bank_detect.sv
module irq_bank_detect
    import irq_bank_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic      [NCH-1:0]   lvl,
    input  chan_cfg_t [NCH-1:0]   cfg,
    input  logic      [NCH-1:0]   clr,
    output logic      [NCH-1:0]   hit,
    output logic      [NCH-1:0]   pend
);
    logic [NCH-1:0] prv;

    always_ff @(posedge clk) begin
        if (rst) prv <= '0;
        else     prv <= lvl;
    end

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_chan
            assign hit[c] = chan_hit(cfg[c], lvl[c], prv[c]);

            // A detection in the clearing cycle keeps the bit set.
            always_ff @(posedge clk) begin
                if (rst)         pend[c] <= 1'b0;
                else if (hit[c]) pend[c] <= 1'b1;
                else if (clr[c]) pend[c] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import irq_bank_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int DW       = 32,
    parameter int AW       = ADDR_W,
    parameter int SYNC_LEN = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_clk,
    input  logic          smp_rst,
    input  logic [NCH-1:0] pins_in,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    localparam int PAD = DW - NCH;

    logic [NCH-1:0] smp_lvl;
    logic [NCH-1:0] bus_lvl;
    logic [NCH-1:0] en_q, mode_q, both_q, pol_q;
    logic [NCH-1:0] clr_vec, hit_vec, pend_vec, gated_vec;
    chan_cfg_t [NCH-1:0] cfg_vec;
    logic           wr_go;
    logic [NCH-1:0] wbits;

    // Sampling-domain resample of the raw pins.
    irq_bank_sync #(.W(NCH), .STAGES(SYNC_LEN)) u_smp_sync (
        .clk (smp_clk),
        .rst (smp_rst),
        .d   (pins_in),
        .q   (smp_lvl)
    );

    // Crossing of the sampled levels into the bus domain.
    irq_bank_sync #(.W(NCH), .STAGES(SYNC_LEN)) u_bus_sync (
        .clk (clk),
        .rst (rst),
        .d   (smp_lvl),
        .q   (bus_lvl)
    );

    assign wr_go = bus_sel & bus_wr;
    assign wbits = bus_wdata[NCH-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            mode_q <= '0;
            both_q <= '0;
            pol_q  <= '0;
        end else if (wr_go) begin
            case (bus_addr)
                OFS_ENABLE: en_q   <= wbits;
                OFS_MODE:   mode_q <= wbits;
                OFS_BOTH:   both_q <= wbits;
                OFS_POL:    pol_q  <= wbits;
                default: ;
            endcase
        end
    end

    assign clr_vec = (wr_go && bus_addr == OFS_CLEAR) ? wbits : '0;

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_cfg
            assign cfg_vec[c].kind = mode_q[c] ? DET_LEVEL : DET_EDGE;
            assign cfg_vec[c].both = both_q[c];
            assign cfg_vec[c].pol  = pol_q[c];
        end
    endgenerate

    irq_bank_detect #(.NCH(NCH)) u_detect (
        .clk  (clk),
        .rst  (rst),
        .lvl  (bus_lvl),
        .cfg  (cfg_vec),
        .clr  (clr_vec),
        .hit  (hit_vec),
        .pend (pend_vec)
    );

    assign gated_vec = pend_vec & en_q;
    assign irq       = |gated_vec;

    always_comb begin
        logic [NCH-1:0] sel_bits;
        sel_bits = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                OFS_ENABLE: sel_bits = en_q;
                OFS_RAW:    sel_bits = pend_vec;
                OFS_GATED:  sel_bits = gated_vec;
                OFS_MODE:   sel_bits = mode_q;
                OFS_BOTH:   sel_bits = both_q;
                OFS_POL:    sel_bits = pol_q;
                OFS_LEVEL:  sel_bits = bus_lvl;
                default:    sel_bits = '0;
            endcase
        end
        bus_rdata = {{PAD{1'b0}}, sel_bits};
    end
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk
    import irq_bank_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 32,
    parameter int AW  = ADDR_W
) (
    input logic           clk,
    input logic           rst,
    input logic           bus_sel,
    input logic           bus_wr,
    input logic [AW-1:0]  bus_addr,
    input logic [DW-1:0]  bus_wdata,
    input logic [DW-1:0]  bus_rdata,
    input logic           irq,
    input logic [NCH-1:0] pend,
    input logic [NCH-1:0] hit,
    input logic [NCH-1:0] en,
    input logic [NCH-1:0] mode,
    input logic [NCH-1:0] lvl
);
    logic [NCH-1:0] clr_seen;
    assign clr_seen = (bus_sel && bus_wr && bus_addr == OFS_CLEAR) ? bus_wdata[NCH-1:0] : '0;

    AST_PEND_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & ~$past(pend | hit)) == '0)); // R3
    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
        ((hit & ~mode & ~(lvl ^ $past(lvl))) == '0)); // R4
    AST_HIT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~pend & $past(hit)) == '0)); // R5
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & $past(clr_seen) & ~$past(hit)) == '0)); // R6
    AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == OFS_CLEAR) |-> (bus_rdata == '0)); // R6
    AST_IRQ_IS_GATED_OR: assert property (@(posedge clk) disable iff (rst)
        irq == |(pend & en)); // R7
endmodule

bind irq_bank irq_bank_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .pend      (pend_vec),
    .hit       (hit_vec),
    .en        (en_q),
    .mode      (mode_q),
    .lvl       (bus_lvl)
);

// File: tb/irq_bank_tb.sv
`timescale 1ns/1ps
module irq_bank_tb;
    localparam int NCH = 8;

    logic        clk = 0, smp_clk = 0, rst = 1, smp_rst = 1;
    logic [7:0]  pins_in = '0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0, bad = 0;
    bit done = 0;

    always #4  clk = ~clk;
    always #20 smp_clk = ~smp_clk;

    irq_bank u_dut (
        .clk(clk), .rst(rst), .smp_clk(smp_clk), .smp_rst(smp_rst),
        .pins_in(pins_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    function automatic logic [7:0] lvl_active(logic [7:0] pol, logic [7:0] v);
        return (pol & v) | (~pol & ~v);
    endfunction

    function automatic logic [7:0] edge_hits(logic [7:0] pol, logic [7:0] both,
                                             logic [7:0] o, logic [7:0] n);
        logic [7:0] chg;
        chg = o ^ n;
        return chg & (both | (pol & n) | (~pol & o));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic settle();
        repeat (30) @(posedge clk);
    endtask

    task automatic one_case(logic [7:0] en, logic [7:0] md, logic [7:0] bt,
                            logic [7:0] pl, logic [7:0] nv);
        logic [31:0] d;
        logic [7:0]  ov, exp_raw, exp_left;
        ov = pins_in;
        wr(5'h00, {$urandom, en} );
        wr(5'h10, {24'hA5A5A5, md});
        wr(5'h14, {24'h5A5A5A, bt});
        wr(5'h18, {24'hFFFFFF, pl});
        rd(5'h00, d); check("R8 enable readback", d, {24'h0, en});
        rd(5'h10, d); check("R8 mode readback",   d, {24'h0, md});
        rd(5'h14, d); check("R8 both readback",   d, {24'h0, bt});
        rd(5'h18, d); check("R8 pol readback",    d, {24'h0, pl});
        wr(5'h0C, 32'hFF);
        settle();
        @(negedge clk);
        pins_in = nv;
        settle();
        exp_raw = (md & (lvl_active(pl, ov) | lvl_active(pl, nv)))
                | (~md & edge_hits(pl, bt, ov, nv));
        wr(5'h04, 32'hFF);  // ignored
        wr(5'h08, 32'h00);  // ignored
        wr(5'h1C, ~{24'h0, nv}); // ignored
        rd(5'h1C, d); check("R2 level data", d, {24'h0, nv});
        rd(5'h04, d); check("R3 R4 R5 R9 pending", d, {24'h0, exp_raw});
        rd(5'h08, d); check("R7 gated", d, {24'h0, exp_raw & en});
        check("R7 irq", {31'h0, irq}, {31'h0, |(exp_raw & en)});
        // Clear all: active level channels are set again in the same cycle.
        wr(5'h0C, 32'hFF);
        exp_left = md & lvl_active(pl, nv);
        rd(5'h04, d); check("R5 R6 pending after clear", d, {24'h0, exp_left});
        rd(5'h0C, d); check("R6 clear reads zero", d, 32'h0);
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        repeat (4) @(posedge smp_clk);
        @(negedge clk); rst = 0; smp_rst = 0;
        @(negedge clk);
        check("R1 irq reset", {31'h0, irq}, 32'h0);
        for (int a = 0; a < 32; a += 4) begin
            rd(a[4:0], d);
            check("R1 reset value", d, 32'h0);
        end
        // Directed: rising only, falling only, both with each polarity.
        one_case(8'hFF, 8'h00, 8'h00, 8'h0F, 8'h33);          // R3
        one_case(8'hFF, 8'h00, 8'h00, 8'h0F, 8'h00);          // R3 falls
        one_case(8'hFF, 8'h00, 8'hFF, 8'hF0, 8'hC3);          // R4
        one_case(8'hFF, 8'h00, 8'hFF, 8'h0F, 8'h3C);          // R4
        one_case(8'h0F, 8'hFF, 8'h00, 8'hAA, 8'hA5);          // R5
        // Single channel clear leaves others pending (R6).
        one_case(8'hFF, 8'h00, 8'hFF, 8'h00, 8'h5A);
        @(negedge clk); pins_in = 8'hA5; settle();
        wr(5'h0C, 32'h01);
        rd(5'h04, d); check("R6 partial clear", d, 32'hFE);
        wr(5'h0C, 32'hFF);
        for (int i = 0; i < 40; i++)
            one_case($urandom, $urandom, $urandom, $urandom, $urandom);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule